// File: doc/BRIEF.md
# Rounding Single-Precision Packer

This block takes a floating-point value held in a wide working form and turns it into a 32-bit IEEE-754 single-precision word. The working form has a class code, a sign, a signed unbiased exponent, a left-aligned significand with its integer one at the top, and a sticky bit. The block rounds under one of four modes, denormalizes results that are too small for a normal encoding, and saturates results that are too large. It reports five flags alongside the word.

The block is meant to sit at the write-back end of an arithmetic pipeline. Each request presented with `in_valid` yields the packed word and its flags, registered, on the next cycle with `out_valid`. An underflow-trap enable input changes only when the underflow flag is raised.

Top module: `sp_round_pack`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high, and is low after reset.
- R2: Class 00 (zero) packs to the sign at bit 31 with all other bits 0. Class 10 (infinity) packs to the sign, exponent field 8'hFF and fraction 0. Neither raises a flag.
- R3: Class 11 (NaN) packs to the sign, exponent 8'hFF, and the 23 significand bits just below the integer one as fraction, with fraction bit 22 (the quiet bit) forced to 1. No flag is raised.
- R4: For class 01 (number), the two significand bits below the result LSB are guard and round. All lower bits and `in_sticky` form sticky. If guard, round and sticky are all 0, no flag is raised. Otherwise both `o_inexact` and `o_frac_inexact` are set.
- R5: Mode 00 (nearest-even) adds one LSB only when guard is set and at least one of round, sticky or the result LSB is 1.
- R6: Mode 01 (toward zero) never adds. Mode 10 (toward +inf) adds on any inexact positive value. Mode 11 (toward -inf) adds on any inexact negative value. Every add sets `o_round_up`.
- R7: When rounding a normal carries the significand to 2.0, the exponent field rises by one and the fraction is 0.
- R8: A biased exponent (unbiased + 127) of 0 or less gives a subnormal. The significand, integer one included, is shifted right by 1 minus the biased exponent before rounding, and the exponent field is 0.
- R9: A subnormal whose rounding carries into bit 23 packs as the smallest normal (exponent field 1, fraction 0) and does not raise underflow.
- R10: A result that stays subnormal raises `o_underflow` if it is inexact or if `in_unf_trap_en` is 1. Otherwise underflow stays 0.
- R11: A biased exponent of 255 or more after rounding overflows. Mode 00 gives infinity. Mode 01 gives the largest finite value (exponent 8'hFE, fraction all ones). Mode 10 gives infinity only for positive values, and mode 11 only for negative values. `o_overflow` is set exactly when infinity is produced this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Significand, integer one at the MSB |
| in_sticky | input | 1 | OR of bits already discarded below the significand |
| in_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| in_unf_trap_en | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Result strobe |
| out_word | output | 32 | Packed single-precision word |
| o_inexact | output | 1 | Result was not exact |
| o_frac_inexact | output | 1 | Fraction was not exact |
| o_round_up | output | 1 | Rounding added one LSB |
| o_overflow | output | 1 | Overflow produced infinity |
| o_underflow | output | 1 | Tiny result, inexact or trap enabled |

## Verification
The hardest case to reach is a value just below the normal range that rounds into it, since it needs a biased exponent of exactly 0 and a significand whose kept bits are all ones. The stimulus builds it from an all-ones significand at exponent -127, and sets the trap enable so that a missing underflow exemption would show. Deep denormal shifts are reached with exponents far below -150, where every bit lands in sticky. These are checked under both truncating and directed modes.

// File: rtl/sp_round_pack.sv
module sp_round_pack #(
  parameter int MANT_W = 32,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        in_mode,
  input  logic              in_unf_trap_en,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic              o_inexact,
  output logic              o_frac_inexact,
  output logic              o_round_up,
  output logic              o_overflow,
  output logic              o_underflow
);
  localparam int FRAC_W = 23;
  localparam int KEEP_W = FRAC_W + 3;
  localparam int LOW_W  = MANT_W - KEEP_W;
  localparam int BW     = EXP_W + 3;
  localparam int SH_W   = $clog2(KEEP_W + 2);
  localparam int BIAS   = 127;

  logic signed [BW-1:0] biased, shv, exp_n;
  logic                 is_sub, stk, lost, g, r, inx, inc, to_inf, promote;
  logic [SH_W-1:0]      sh;
  logic [2*KEEP_W-1:0]  wide;
  logic [KEEP_W-1:0]    keep;
  logic [FRAC_W:0]      body;
  logic [FRAC_W+1:0]    sum;
  logic [31:0]          word_d;
  logic [4:0]           flg_d;

  assign biased = $signed({{3{in_exp[EXP_W-1]}}, in_exp}) + BW'(BIAS);
  assign is_sub = biased <= 0;
  assign shv    = BW'(1) - biased;

  always_comb begin
    if (!is_sub)                 sh = '0;
    else if (shv > KEEP_W)       sh = SH_W'(KEEP_W + 1);
    else                         sh = shv[SH_W-1:0];
  end

  assign wide = {in_mant[MANT_W-1 -: KEEP_W], {KEEP_W{1'b0}}} >> sh;
  assign keep = wide[2*KEEP_W-1:KEEP_W];
  assign lost = |wide[KEEP_W-1:0];
  assign stk  = in_sticky | (|in_mant[LOW_W-1:0]) | lost;
  assign body = keep[KEEP_W-1:2];
  assign g    = keep[1];
  assign r    = keep[0];
  assign inx  = g | r | stk;

  always_comb begin
    unique case (in_mode)
      2'b00:   inc = g & (r | stk | body[0]);
      2'b01:   inc = 1'b0;
      2'b10:   inc = inx & ~in_sign;
      default: inc = inx & in_sign;
    endcase
  end

  always_comb begin
    unique case (in_mode)
      2'b00:   to_inf = 1'b1;
      2'b01:   to_inf = 1'b0;
      2'b10:   to_inf = ~in_sign;
      default: to_inf = in_sign;
    endcase
  end

  assign sum     = {1'b0, body} + {{(FRAC_W+1){1'b0}}, inc};
  assign exp_n   = biased + BW'(sum[FRAC_W+1]);
  assign promote = sum[FRAC_W];

  always_comb begin
    word_d = {in_sign, 31'b0};
    flg_d  = '0;
    unique case (in_class)
      2'b00: word_d = {in_sign, 31'b0};
      2'b10: word_d = {in_sign, 8'hFF, 23'b0};
      2'b11: word_d = {in_sign, 8'hFF, 1'b1, in_mant[MANT_W-3 -: FRAC_W-1]};
      default: begin
        flg_d[4:2] = {inx, inx, inc};
        if (is_sub) begin
          word_d   = {in_sign, 7'b0, promote, sum[FRAC_W-1:0]};
          flg_d[0] = ~promote & (inx | in_unf_trap_en);
        end else if (exp_n >= BW'(255)) begin
          word_d   = to_inf ? {in_sign, 8'hFF, 23'b0} : {in_sign, 8'hFE, {FRAC_W{1'b1}}};
          flg_d[1] = to_inf;
        end else begin
          word_d   = {in_sign, exp_n[7:0], sum[FRAC_W-1:0]};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      {o_inexact, o_frac_inexact, o_round_up, o_overflow, o_underflow} <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= word_d;
        {o_inexact, o_frac_inexact, o_round_up, o_overflow, o_underflow} <= flg_d;
      end
    end
  end
endmodule

module sp_round_pack_chk #(
  parameter int MANT_W = 32,
  parameter int EXP_W  = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_class,
  input logic [1:0]  in_mode,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        o_inexact,
  input logic        o_round_up,
  input logic        o_overflow,
  input logic        o_underflow
);
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_zero_pack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'b00) |=> (out_word[30:0] == 31'b0 && !o_inexact));
  assert_round_needs_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_round_up) |-> o_inexact);
  assert_trunc_no_round_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01) |=> !o_round_up);
  assert_unf_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_underflow) |-> out_word[30:23] == 8'h00);
  assert_ovf_is_inf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_overflow) |-> out_word[30:0] == {8'hFF, 23'b0});
endmodule

bind sp_round_pack sp_round_pack_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
  .in_mode(in_mode), .out_valid(out_valid), .out_word(out_word),
  .o_inexact(o_inexact), .o_round_up(o_round_up),
  .o_overflow(o_overflow), .o_underflow(o_underflow)
);

// File: tb/sp_round_pack_tb.sv
module sp_round_pack_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_class = '0;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [31:0] in_mant = '0;
  logic        in_sticky = 1'b0;
  logic [1:0]  in_mode = '0;
  logic        in_unf_trap_en = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        o_inexact, o_frac_inexact, o_round_up, o_overflow, o_underflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] word;
    logic [4:0]  flags;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  sp_round_pack u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .in_mode(in_mode), .in_unf_trap_en(in_unf_trap_en), .out_valid(out_valid),
    .out_word(out_word), .o_inexact(o_inexact), .o_frac_inexact(o_frac_inexact),
    .o_round_up(o_round_up), .o_overflow(o_overflow), .o_underflow(o_underflow)
  );

  // flags order: {inexact, frac_inexact, round_up, overflow, underflow}
  task automatic send(input logic [1:0] cls, input logic s, input int e,
                      input logic [31:0] m, input logic st, input logic [1:0] md,
                      input logic trap, input logic [31:0] w, input logic [4:0] f,
                      input string tag);
    exp_t item;
    @(negedge clk);
    in_valid = 1'b1; in_class = cls; in_sign = s; in_exp = 10'(e);
    in_mant = m; in_sticky = st; in_mode = md; in_unf_trap_en = trap;
    item.word = w; item.flags = f; item.tag = tag;
    sb.push_back(item);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R1 unexpected out_valid actual=1 expected=0");
      end else begin
        exp_t it;
        it = sb.pop_front();
        if (out_word !== it.word ||
            {o_inexact, o_frac_inexact, o_round_up, o_overflow, o_underflow} !== it.flags) begin
          failures++;
          $display("FAIL %s actual=%h/%b expected=%h/%b", it.tag, out_word,
                   {o_inexact, o_frac_inexact, o_round_up, o_overflow, o_underflow},
                   it.word, it.flags);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'h0) begin
      failures++;
      $display("FAIL R1 reset actual=%b/%h expected=0/00000000", out_valid, out_word);
    end
    rst_n = 1'b1;
    @(negedge clk);

    send(2'b01, 0, 0,    32'h80000000, 0, 2'b00, 0, 32'h3F800000, 5'b00000, "R4 exact one");
    send(2'b00, 1, 0,    32'h0,        0, 2'b00, 0, 32'h80000000, 5'b00000, "R2 neg zero");
    send(2'b10, 0, 0,    32'h0,        0, 2'b00, 0, 32'h7F800000, 5'b00000, "R2 infinity");
    send(2'b11, 1, 0,    32'h80000100, 0, 2'b00, 0, 32'hFFC00001, 5'b00000, "R3 nan quiet");
    send(2'b01, 0, 0,    32'h80000080, 0, 2'b00, 0, 32'h3F800000, 5'b11000, "R5 tie even");
    send(2'b01, 0, 0,    32'h80000180, 0, 2'b00, 0, 32'h3F800002, 5'b11100, "R5 tie odd");
    send(2'b01, 0, 0,    32'h80000080, 1, 2'b00, 0, 32'h3F800001, 5'b11100, "R5 guard sticky");
    send(2'b01, 0, 0,    32'h80000040, 0, 2'b00, 0, 32'h3F800000, 5'b11000, "R5 round only");
    send(2'b01, 0, 0,    32'h800000FF, 0, 2'b01, 0, 32'h3F800000, 5'b11000, "R6 toward zero");
    send(2'b01, 0, 0,    32'h80000001, 0, 2'b10, 0, 32'h3F800001, 5'b11100, "R6 plus pos");
    send(2'b01, 1, 0,    32'h80000001, 0, 2'b10, 0, 32'hBF800000, 5'b11000, "R6 plus neg");
    send(2'b01, 1, 0,    32'h80000001, 0, 2'b11, 0, 32'hBF800001, 5'b11100, "R6 minus neg");
    send(2'b01, 0, 0,    32'hFFFFFF80, 0, 2'b00, 0, 32'h40000000, 5'b11100, "R7 carry to two");
    send(2'b01, 0, -127, 32'h80000000, 0, 2'b00, 0, 32'h00400000, 5'b00000, "R8 half subnormal");
    send(2'b01, 0, -127, 32'h80000000, 0, 2'b00, 1, 32'h00400000, 5'b00001, "R10 trap exact");
    send(2'b01, 0, -149, 32'h80000000, 0, 2'b00, 0, 32'h00000001, 5'b00000, "R8 min subnormal");
    send(2'b01, 0, -150, 32'h80000000, 0, 2'b00, 0, 32'h00000000, 5'b11001, "R10 tie to zero");
    send(2'b01, 0, -150, 32'h80000001, 0, 2'b00, 0, 32'h00000001, 5'b11101, "R10 up to min");
    send(2'b01, 0, -127, 32'hFFFFFF80, 0, 2'b00, 1, 32'h00800000, 5'b11100, "R9 promote normal");
    send(2'b01, 0, 128,  32'h80000000, 0, 2'b00, 0, 32'h7F800000, 5'b00010, "R11 nearest inf");
    send(2'b01, 0, 128,  32'h80000000, 0, 2'b01, 0, 32'h7F7FFFFF, 5'b00000, "R11 zero max");
    send(2'b01, 1, 128,  32'h80000000, 0, 2'b10, 0, 32'hFF7FFFFF, 5'b00000, "R11 plus neg max");
    send(2'b01, 1, 128,  32'h80000000, 0, 2'b11, 0, 32'hFF800000, 5'b00010, "R11 minus neg inf");
    send(2'b01, 0, 127,  32'hFFFFFF80, 0, 2'b00, 0, 32'h7F800000, 5'b11110, "R11 round overflow");
    send(2'b01, 0, 300,  32'h80000000, 0, 2'b10, 0, 32'h7F800000, 5'b00010, "R11 huge exp");
    send(2'b01, 0, -300, 32'h80000000, 0, 2'b10, 0, 32'h00000001, 5'b11101, "R8 deep plus");
    send(2'b01, 0, -300, 32'h80000000, 0, 2'b01, 0, 32'h00000000, 5'b11001, "R8 deep trunc");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R1 missing results actual=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule